// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block runs a complete sector or block erase on a serial NOR flash without software stepping through the commands. Software first loads the target address, then pulses a trigger. The sequencer opens a chip-select frame for the write-enable instruction. It then sends the erase instruction followed by the address, and after that it keeps reading the flash status byte until the device no longer reports busy. A running erase can be paused with a suspend instruction so that other traffic can reach the flash, and it is continued later with a resume instruction.

All opcodes, the address width, and the position and polarity of the busy flag come from configuration inputs. Two timers set the bus spacing. One holds chip select idle for a programmed number of clock cycles after every state-changing command. The other enforces a programmed wait between an erase or resume command and the next status read. A three-bit status output reports the progress of the erase. The serial side runs in SPI mode 0 with one data line per direction. Each serial bit lasts two system clocks: SCK is low in the first and high in the second.

Top module: `erase_seq`

## Requirements
- R1: Out of reset, status_o reads 0, cs_no is high, sck_o is low, and no frame is started until a trigger arrives.
- R2: status_o encodes 0 = no erase, 1 = pending, 2 = erasing, 3 = suspended, 4 = finishing. It reads 1 in the cycle after the trigger is sampled and stays 1 until the erase frame ends. It reads 2 while status polling is in progress.
- R3: A trigger sends a frame carrying only the 8-bit write-enable opcode. The next frame carries the erase opcode followed by the address, MSB first. MOSI changes while SCK is low and is sampled on the SCK rising edge, and SCK toggles only while cs_no is low.
- R4: With addr4b_i = 1 the erase frame carries all 32 address bits (40 bits in total). With addr4b_i = 0 it carries only address bits 23..0 (32 bits in total).
- R5: After a write-enable, erase, suspend or resume frame, cs_no stays high for at least cs_gap_i clock cycles before the next frame starts.
- R6: After an erase or resume frame ends, at least rdsr_gap_i clock cycles pass before the next status-read frame starts.
- R7: Status polling repeats a 16-clock frame. The frame carries the read-status opcode and then 8 cycles in which the status byte arrives MSB first on miso_i. The flash is busy when bit busy_bit_i of that byte equals busy_high_i. Once a read shows not busy, status_o reads 4 for at least cs_gap_i cycles, then returns to 0, and no further frame is sent.
- R8: A trigger received while status_o is not 0 is ignored. An address write during an erase does not change the address of that erase.
- R9: A suspend pulse while status_o is 2 sends a suspend-opcode frame once the current poll ends (or at once if no poll is in flight), after which status_o reads 3 and no frame is sent. A later resume pulse sends a resume-opcode frame, and polling then continues. A suspend pulse while status_o is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Erase address to load |
| addr_we_i | input | 1 | Loads addr_i into the address register |
| trigger_i | input | 1 | Starts an erase when status is 0 |
| suspend_i | input | 1 | Requests suspension of a running erase |
| resume_i | input | 1 | Requests continuation of a suspended erase |
| op_wren_i | input | 8 | Write-enable opcode |
| op_erase_i | input | 8 | Erase opcode |
| op_rdsr_i | input | 8 | Read-status opcode |
| op_susp_i | input | 8 | Erase-suspend opcode |
| op_resm_i | input | 8 | Erase-resume opcode |
| addr4b_i | input | 1 | 1: 32-bit address, 0: 24-bit address |
| busy_bit_i | input | 3 | Bit position of the busy flag in the status byte |
| busy_high_i | input | 1 | Level of the busy flag when the flash is busy |
| cs_gap_i | input | 8 | Minimum chip-select idle cycles after a command |
| rdsr_gap_i | input | 8 | Minimum cycles from an erase or resume frame to a status read |
| status_o | output | 3 | Erase progress code |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
The bench builds the block with the default parameters: 8-bit opcodes, a 32-bit full address with a 24-bit short form, and 8-bit gap counters. These settings give both erase-frame lengths and let every busy-bit position in the status byte be tested. A flash model in the bench replies with status bytes in which the busy bit takes one level and all other bits take the opposite level. A misread position or polarity therefore changes the number of polls. The gap values in the vectors run from zero up to a read delay longer than the command gap, so each of the two timers is in turn the one that limits the spacing.

// File: rtl/eseq_pkg.sv
package eseq_pkg;
  typedef enum logic [2:0] {
    ST_NONE    = 3'd0,
    ST_PEND    = 3'd1,
    ST_ERASING = 3'd2,
    ST_SUSP    = 3'd3,
    ST_FINISH  = 3'd4
  } erase_stat_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_WREN_X, S_ERS, S_ERS_X, S_POLL, S_POLL_X,
    S_SUS_X, S_SUSD, S_RES_X, S_FIN
  } seq_state_e;

  typedef enum logic [2:0] {
    C_WREN, C_ERASE, C_RDSR, C_SUSP, C_RESM
  } cmd_e;
endpackage

// File: rtl/eseq_shift.sv
module eseq_shift #(
  parameter int XFER_W = 40,
  parameter int RX_W   = 8,
  parameter int CNT_W  = $clog2(XFER_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic [XFER_W-1:0] data_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [RX_W-1:0]   rx_o
);
  logic [XFER_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ph_q, busy_q, done_q;
  logic [RX_W-1:0]   rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          sr_q   <= data_i;
          cnt_q  <= nbits_i;
          ph_q   <= 1'b0;
        end
      end else if (!ph_q) begin
        // rising SCK: capture input
        ph_q <= 1'b1;
        rx_q <= {rx_q[RX_W-2:0], miso_i};
      end else begin
        ph_q  <= 1'b0;
        sr_q  <= {sr_q[XFER_W-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sck_o  = busy_q & ph_q;
  assign mosi_o = busy_q & sr_q[XFER_W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/eseq_gap.sv
module eseq_gap #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eseq_ctrl.sv
module eseq_ctrl import eseq_pkg::*; #(
  parameter int OP_W         = 8,
  parameter int ADDR_W       = 32,
  parameter int ADDR_SHORT_W = 24,
  parameter int XFER_W       = OP_W + ADDR_W,
  parameter int CNT_W        = $clog2(XFER_W + 1),
  parameter int POS_W        = $clog2(OP_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_we_i,
  input  logic              trigger_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic [OP_W-1:0]   op_wren_i,
  input  logic [OP_W-1:0]   op_erase_i,
  input  logic [OP_W-1:0]   op_rdsr_i,
  input  logic [OP_W-1:0]   op_susp_i,
  input  logic [OP_W-1:0]   op_resm_i,
  input  logic              addr4b_i,
  input  logic [POS_W-1:0]  busy_bit_i,
  input  logic              busy_high_i,
  input  logic              sh_done_i,
  input  logic [OP_W-1:0]   sh_rx_i,
  input  logic              gap_zero_i,
  input  logic              rd_zero_i,
  output logic              sh_start_o,
  output logic [CNT_W-1:0]  sh_nbits_o,
  output logic [XFER_W-1:0] sh_data_o,
  output logic              gap_load_o,
  output logic              rd_load_o,
  output erase_stat_e       status_o
);
  localparam int PAD_W = ADDR_W - ADDR_SHORT_W;

  seq_state_e        st_q, st_d;
  cmd_e              sel;
  logic [ADDR_W-1:0] addr_q, work_q;
  logic              sus_req_q, res_req_q;
  logic              flash_busy;

  assign flash_busy = (sh_rx_i[busy_bit_i] == busy_high_i);

  always_comb begin
    st_d       = st_q;
    sh_start_o = 1'b0;
    sel        = C_RDSR;
    gap_load_o = 1'b0;
    rd_load_o  = 1'b0;
    case (st_q)
      S_IDLE:   if (trigger_i) st_d = S_WREN;
      S_WREN:   if (gap_zero_i) begin
                  sh_start_o = 1'b1; sel = C_WREN; st_d = S_WREN_X;
                end
      S_WREN_X: if (sh_done_i) begin gap_load_o = 1'b1; st_d = S_ERS; end
      S_ERS:    if (gap_zero_i) begin
                  sh_start_o = 1'b1; sel = C_ERASE; st_d = S_ERS_X;
                end
      S_ERS_X:  if (sh_done_i) begin
                  gap_load_o = 1'b1; rd_load_o = 1'b1; st_d = S_POLL;
                end
      S_POLL:   if (sus_req_q && gap_zero_i) begin
                  sh_start_o = 1'b1; sel = C_SUSP; st_d = S_SUS_X;
                end else if (gap_zero_i && rd_zero_i) begin
                  sh_start_o = 1'b1; sel = C_RDSR; st_d = S_POLL_X;
                end
      S_POLL_X: if (sh_done_i) begin
                  if (flash_busy) st_d = S_POLL;
                  else begin gap_load_o = 1'b1; st_d = S_FIN; end
                end
      S_SUS_X:  if (sh_done_i) begin gap_load_o = 1'b1; st_d = S_SUSD; end
      S_SUSD:   if (res_req_q && gap_zero_i) begin
                  sh_start_o = 1'b1; sel = C_RESM; st_d = S_RES_X;
                end
      S_RES_X:  if (sh_done_i) begin
                  gap_load_o = 1'b1; rd_load_o = 1'b1; st_d = S_POLL;
                end
      S_FIN:    if (gap_zero_i) st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  // frame content, left aligned
  always_comb begin
    sh_data_o  = {op_rdsr_i, {ADDR_W{1'b0}}};
    sh_nbits_o = CNT_W'(2 * OP_W);
    case (sel)
      C_WREN: begin
        sh_data_o  = {op_wren_i, {ADDR_W{1'b0}}};
        sh_nbits_o = CNT_W'(OP_W);
      end
      C_ERASE: begin
        if (addr4b_i) begin
          sh_data_o  = {op_erase_i, work_q};
          sh_nbits_o = CNT_W'(OP_W + ADDR_W);
        end else begin
          sh_data_o  = {op_erase_i, work_q[ADDR_SHORT_W-1:0], {PAD_W{1'b0}}};
          sh_nbits_o = CNT_W'(OP_W + ADDR_SHORT_W);
        end
      end
      C_SUSP: begin
        sh_data_o  = {op_susp_i, {ADDR_W{1'b0}}};
        sh_nbits_o = CNT_W'(OP_W);
      end
      C_RESM: begin
        sh_data_o  = {op_resm_i, {ADDR_W{1'b0}}};
        sh_nbits_o = CNT_W'(OP_W);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      addr_q    <= '0;
      work_q    <= '0;
      sus_req_q <= 1'b0;
      res_req_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (addr_we_i) addr_q <= addr_i;
      if (st_q == S_IDLE && trigger_i) work_q <= addr_q;

      if (st_q == S_IDLE || st_q == S_FIN)
        sus_req_q <= 1'b0;
      else if (sh_start_o && sel == C_SUSP)
        sus_req_q <= 1'b0;
      else if (suspend_i && (st_q == S_POLL || st_q == S_POLL_X))
        sus_req_q <= 1'b1;

      if (sh_start_o && sel == C_RESM)
        res_req_q <= 1'b0;
      else if (resume_i && st_q == S_SUSD)
        res_req_q <= 1'b1;
    end
  end

  always_comb begin
    case (st_q)
      S_IDLE:                             status_o = ST_NONE;
      S_WREN, S_WREN_X, S_ERS, S_ERS_X:   status_o = ST_PEND;
      S_SUSD:                             status_o = ST_SUSP;
      S_FIN:                              status_o = ST_FINISH;
      default:                            status_o = ST_ERASING;
    endcase
  end
endmodule

// File: rtl/erase_seq.sv
module erase_seq import eseq_pkg::*; #(
  parameter int OP_W         = 8,
  parameter int ADDR_W       = 32,
  parameter int ADDR_SHORT_W = 24,
  parameter int GAP_W        = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     addr_we_i,
  input  logic                     trigger_i,
  input  logic                     suspend_i,
  input  logic                     resume_i,
  input  logic [OP_W-1:0]          op_wren_i,
  input  logic [OP_W-1:0]          op_erase_i,
  input  logic [OP_W-1:0]          op_rdsr_i,
  input  logic [OP_W-1:0]          op_susp_i,
  input  logic [OP_W-1:0]          op_resm_i,
  input  logic                     addr4b_i,
  input  logic [$clog2(OP_W)-1:0]  busy_bit_i,
  input  logic                     busy_high_i,
  input  logic [GAP_W-1:0]         cs_gap_i,
  input  logic [GAP_W-1:0]         rdsr_gap_i,
  output logic [2:0]               status_o,
  output logic                     sck_o,
  output logic                     cs_no,
  output logic                     mosi_o,
  input  logic                     miso_i
);
  localparam int XFER_W = OP_W + ADDR_W;
  localparam int CNT_W  = $clog2(XFER_W + 1);
  localparam int POS_W  = $clog2(OP_W);
  localparam int N_TMR  = 2;

  logic              sh_start, sh_done, sh_busy;
  logic [CNT_W-1:0]  sh_nbits;
  logic [XFER_W-1:0] sh_data;
  logic [OP_W-1:0]   sh_rx;
  logic [N_TMR-1:0]  t_load, t_zero;
  logic [GAP_W-1:0]  t_val [N_TMR];
  erase_stat_e       stat;

  assign t_val[0] = cs_gap_i;
  assign t_val[1] = rdsr_gap_i;

  eseq_ctrl #(
    .OP_W(OP_W), .ADDR_W(ADDR_W), .ADDR_SHORT_W(ADDR_SHORT_W),
    .XFER_W(XFER_W), .CNT_W(CNT_W), .POS_W(POS_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .addr_we_i, .trigger_i, .suspend_i, .resume_i,
    .op_wren_i, .op_erase_i, .op_rdsr_i, .op_susp_i, .op_resm_i,
    .addr4b_i, .busy_bit_i, .busy_high_i,
    .sh_done_i  (sh_done),
    .sh_rx_i    (sh_rx),
    .gap_zero_i (t_zero[0]),
    .rd_zero_i  (t_zero[1]),
    .sh_start_o (sh_start),
    .sh_nbits_o (sh_nbits),
    .sh_data_o  (sh_data),
    .gap_load_o (t_load[0]),
    .rd_load_o  (t_load[1]),
    .status_o   (stat)
  );

  eseq_shift #(.XFER_W(XFER_W), .RX_W(OP_W), .CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni,
    .start_i (sh_start),
    .nbits_i (sh_nbits),
    .data_i  (sh_data),
    .miso_i,
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .sck_o,
    .mosi_o,
    .rx_o    (sh_rx)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    eseq_gap #(.W(GAP_W)) u_gap (
      .clk_i, .rst_ni,
      .load_i (t_load[g]),
      .val_i  (t_val[g]),
      .zero_o (t_zero[g])
    );
  end

  assign cs_no    = ~sh_busy;
  assign status_o = stat;
endmodule

// File: rtl/eseq_chk.sv
module eseq_chk #(
  parameter int OP_W  = 8,
  parameter int GAP_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       status_o,
  input logic             cs_no,
  input logic             sck_o,
  input logic             mosi_o,
  input logic             trigger_i,
  input logic [OP_W-1:0]  op_wren_i,
  input logic [OP_W-1:0]  op_erase_i,
  input logic [OP_W-1:0]  op_susp_i,
  input logic [OP_W-1:0]  op_resm_i,
  input logic [GAP_W-1:0] cs_gap_i
);
  logic [OP_W-1:0] op_q;
  logic [3:0]      nb_q;
  logic            sck_q, seen_q, cs_q;
  logic [15:0]     idle_q;
  logic            gap_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= '0; nb_q <= '0; sck_q <= 1'b0; seen_q <= 1'b0;
      idle_q <= '0; cs_q <= 1'b1;
    end else begin
      sck_q <= sck_o;
      cs_q  <= cs_no;
      if (cs_no) begin
        nb_q <= '0;
        if (idle_q != 16'hffff) idle_q <= idle_q + 1'b1;
      end else begin
        idle_q <= '0;
        seen_q <= 1'b1;
        if (sck_o && !sck_q && nb_q < 4'(OP_W)) begin
          op_q <= {op_q[OP_W-2:0], mosi_o};
          nb_q <= nb_q + 1'b1;
        end
      end
    end
  end

  assign gap_op = seen_q && (op_q == op_wren_i || op_q == op_erase_i ||
                             op_q == op_susp_i || op_q == op_resm_i);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 3'd0 |-> cs_no);
  p_status_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o <= 3'd4);
  p_sck_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  p_cmd_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_q && !cs_no && gap_op) |-> idle_q >= 16'(cs_gap_i));
  p_trig_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd2 && trigger_i) |=> status_o != 3'd1);
  p_susp_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 3'd3 |-> cs_no);
endmodule

bind erase_seq eseq_chk #(.OP_W(OP_W), .GAP_W(GAP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .status_o(status_o), .cs_no(cs_no),
  .sck_o(sck_o), .mosi_o(mosi_o), .trigger_i(trigger_i),
  .op_wren_i(op_wren_i), .op_erase_i(op_erase_i), .op_susp_i(op_susp_i),
  .op_resm_i(op_resm_i), .cs_gap_i(cs_gap_i)
);

// File: tb/tb_erase_seq.sv
module tb_erase_seq;
  localparam logic [7:0] OP_WREN = 8'h06, OP_ERS = 8'h20, OP_RD = 8'h05;
  localparam logic [7:0] OP_SUS = 8'h75, OP_RES = 8'h7A;

  typedef struct packed {
    logic [31:0] addr; logic a4; logic [2:0] pos; logic lvl;
    logic [7:0] polls; logic [7:0] gap; logic [7:0] dly;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{32'h0012_3456, 1'b0, 3'd0, 1'b1, 8'd2, 8'd3, 8'd5},
    '{32'hA5C3_0F96, 1'b1, 3'd0, 1'b1, 8'd0, 8'd0, 8'd0},
    '{32'h00FF_0100, 1'b0, 3'd5, 1'b0, 8'd3, 8'd6, 8'd2},
    '{32'h8000_0001, 1'b1, 3'd7, 1'b1, 8'd1, 8'd1, 8'd9}
  };

  logic clk = 0, rst_n = 0;
  logic [31:0] addr = 0; logic addr_we = 0, trig = 0, susp = 0, resm = 0;
  logic a4 = 0; logic [2:0] bpos = 0; logic blvl = 1;
  logic [7:0] gap = 0, dly = 0;
  logic [2:0] status; logic sck, cs_n, mosi; logic miso = 0;

  always #4 clk = ~clk;

  erase_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .addr_we_i(addr_we),
    .trigger_i(trig), .suspend_i(susp), .resume_i(resm),
    .op_wren_i(OP_WREN), .op_erase_i(OP_ERS), .op_rdsr_i(OP_RD),
    .op_susp_i(OP_SUS), .op_resm_i(OP_RES), .addr4b_i(a4),
    .busy_bit_i(bpos), .busy_high_i(blvl), .cs_gap_i(gap), .rdsr_gap_i(dly),
    .status_o(status), .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int nfr = 0, busy_left = 0;
  logic [7:0]  f_op  [64];
  int          f_bits[64];
  logic [63:0] f_sh  [64];
  int          f_gap [64];
  logic [4:0]  seen = 0;

  // flash model, sampled away from the active edge
  logic prev_cs = 1, prev_sck = 0, is_rd = 0;
  logic [63:0] sh = 0; int bits = 0, idle = 0; logic [7:0] sbyte = 0;
  always @(negedge clk) begin
    if (status <= 3'd4) seen[status] <= 1'b1;
    if (!cs_n) begin
      if (prev_cs) begin
        bits = 0; sh = 0; is_rd = 0;
        if (nfr < 64) f_gap[nfr] = idle;
      end
      if (sck && !prev_sck) begin sh = {sh[62:0], mosi}; bits++; end
      if (!sck && prev_sck && bits >= 8) begin
        if (bits == 8 && sh[7:0] == OP_RD) begin
          is_rd = 1;
          if (busy_left > 0) sbyte = blvl ? (8'h1 << bpos) : ~(8'h1 << bpos);
          else               sbyte = blvl ? ~(8'h1 << bpos) : (8'h1 << bpos);
        end
        if (is_rd && bits < 16) miso <= sbyte[15 - bits];
      end
      idle = 0;
    end else begin
      if (!prev_cs) begin
        if (nfr < 64) begin
          f_op[nfr] = 8'(sh >> (bits - 8)); f_bits[nfr] = bits; f_sh[nfr] = sh;
        end
        nfr++;
        if (is_rd && busy_left > 0) busy_left--;
      end
      idle++;
    end
    prev_cs = cs_n; prev_sck = sck;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1; @(negedge clk) s = 0;
  endtask

  task automatic wait_stat(input logic [2:0] v, input string req);
    int t = 0;
    while (status != v && t < 20000) begin @(negedge clk); t++; end
    chk(status == v, req, status, v);
  endtask

  task automatic wait_frames(input int n);
    int t = 0;
    while (nfr < n && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic start_erase(input logic [31:0] a, input string req);
    @(negedge clk) addr = a; addr_we = 1;
    @(negedge clk) addr_we = 0; nfr = 0; seen = 0; trig = 1;
    @(negedge clk) trig = 0;
    chk(status == 3'd1, req, status, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(status == 0 && cs_n && !sck, "R1 reset", {status, cs_n, sck}, 3'b0_10);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(nfr == 0 && cs_n, "R1 no frame after reset", nfr, 0);

    foreach (VECS[i]) begin
      vec_t v; logic [31:0] ea; int nexp;
      v = VECS[i];
      a4 = v.a4; bpos = v.pos; blvl = v.lvl; gap = v.gap; dly = v.dly;
      busy_left = int'(v.polls);
      start_erase(v.addr, "R2 pending after trigger");
      wait_stat(3'd0, "R7 erase completes");
      nexp = 3 + int'(v.polls);
      chk(nfr == nexp, "R7 poll count", nfr, nexp);
      chk(f_op[0] == OP_WREN && f_bits[0] == 8, "R3 write-enable frame", f_op[0], OP_WREN);
      chk(f_op[1] == OP_ERS, "R3 erase opcode", f_op[1], OP_ERS);
      chk(f_bits[1] == (v.a4 ? 40 : 32), "R4 erase frame length", f_bits[1], v.a4 ? 40 : 32);
      ea = v.a4 ? v.addr : {8'h00, v.addr[23:0]};
      chk((v.a4 ? f_sh[1][31:0] : {8'h00, f_sh[1][23:0]}) == ea, "R4 erase address",
          f_sh[1][31:0], ea);
      chk(f_gap[1] >= int'(v.gap), "R5 gap after write-enable", f_gap[1], v.gap);
      chk(f_gap[2] >= int'(v.gap), "R5 gap after erase", f_gap[2], v.gap);
      chk(f_gap[2] >= int'(v.dly), "R6 erase to status read", f_gap[2], v.dly);
      for (int k = 2; k < nexp && k < 64; k++)
        chk(f_op[k] == OP_RD && f_bits[k] == 16, "R7 status read frame", f_op[k], OP_RD);
      chk(seen[2] && seen[4], "R2 erasing and finishing seen", seen, 5'b10100);
    end

    // R8: trigger and address write during erase are ignored
    a4 = 1; bpos = 0; blvl = 1; gap = 2; dly = 2; busy_left = 4;
    start_erase(32'h1357_9BDF, "R2 pending");
    wait_frames(3);
    @(negedge clk) addr = 32'hDEAD_BEEF; addr_we = 1;
    @(negedge clk) addr_we = 0; trig = 1;
    @(negedge clk) trig = 0;
    wait_stat(3'd0, "R8 erase completes");
    repeat (30) @(negedge clk);
    chk(nfr == 7, "R8 no second sequence", nfr, 7);
    chk(f_sh[1][31:0] == 32'h1357_9BDF, "R8 address unchanged", f_sh[1][31:0], 32'h1357_9BDF);

    // R9: suspend while idle has no effect
    nfr = 0; pulse(susp);
    repeat (20) @(negedge clk);
    chk(nfr == 0 && status == 0, "R9 suspend ignored when idle", nfr, 0);

    // R9: suspend and resume
    a4 = 0; gap = 4; dly = 7; busy_left = 6;
    start_erase(32'h0000_4000, "R2 pending");
    wait_frames(3);
    pulse(susp);
    wait_stat(3'd3, "R9 suspended");
    chk(nfr > 0 && nfr < 64 && f_op[nfr-1] == OP_SUS, "R9 suspend frame",
        nfr > 0 ? f_op[nfr-1] : 0, OP_SUS);
    begin
      int n0; n0 = nfr;
      repeat (40) @(negedge clk);
      chk(nfr == n0 && status == 3, "R9 quiet while suspended", nfr, n0);
      pulse(resm);
      wait_stat(3'd0, "R9 erase completes after resume");
      chk(n0 + 1 < 64 && f_op[n0] == OP_RES, "R9 resume frame", f_op[n0], OP_RES);
      chk(f_gap[n0] >= 4, "R5 gap after suspend", f_gap[n0], 4);
      chk(f_op[n0+1] == OP_RD && f_gap[n0+1] >= 7, "R6 resume to status read",
          f_gap[n0+1], 7);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule